// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A 7-bit line-control word sets the shape of each frame: the number of data bits (5 to 8), a long or short stop period, whether a parity bit is sent, and which kind of parity it is (odd, even, or a constant one or zero). A separate bit in the same word forces the line low at any time, so the far end sees a line break.

Bit timing comes from an external tick that pulses for one clock cycle at sixteen times the bit rate. Every serial bit lasts sixteen ticks. Bytes enter through a valid/ready handshake, and the framing in the control word is captured at the moment a byte is accepted. The busy output stays high while a frame is on the line or a break is held.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, busy is 0 and ready is 1. The captured framing is all zero.
- R2: A frame is a low start bit followed by the data bits, least significant first. Each bit lasts 16 ticks and the line changes only on a tick. lineCtrl[1:0] = 0, 1, 2, 3 gives 5, 6, 7, 8 data bits. Between frames the line is high.
- R3: A byte is taken in the cycle where txValid and txReady are both high. txReady is high only while no frame is running and no break is held. busy goes high in the cycle after a byte is taken.
- R4: lineCtrl[2] = 0 gives a high stop period of 16 ticks. lineCtrl[2] = 1 gives 24 ticks for 5-bit words and 32 ticks for other word lengths. busy falls at the tick that ends the stop period.
- R5: When lineCtrl[3] = 0, no parity bit is sent and the stop period follows the last data bit directly.
- R6: When lineCtrl[3] = 1 and lineCtrl[5] = 0, one parity bit follows the data. lineCtrl[4] = 0 makes the number of ones in data plus parity odd, and lineCtrl[4] = 1 makes it even. Only the selected data bits are counted.
- R7: When lineCtrl[3] = 1 and lineCtrl[5] = 1, the parity bit is 1 if lineCtrl[4] = 0 and 0 if lineCtrl[4] = 1.
- R8: While lineCtrl[6] = 1, the line is low in that same cycle, whatever the frame state. Ready is 0 and busy is 1. A byte offered during a break is not taken.
- R9: When lineCtrl[6] returns to 0, the line is high at once and busy is 0. The interrupted frame is dropped and never resumes.
- R10: Changes to lineCtrl[5:0] after a byte is taken have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| lineCtrl | input | 7 | Framing control: [1:0] word length, [2] long stop, [3] parity on, [4] even select, [5] forced parity, [6] break |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | txData is offered |
| txReady | output | 1 | A byte can be accepted |
| txOut | output | 1 | Serial line |
| busy | output | 1 | Frame in progress or break held |

## Verification
Break control and frame handling can act in the same cycle. The bench provokes this in two ways. First, it raises the break bit in the same negedge where it offers a byte with txValid. Second, it raises break partway through a frame of all-zero data, so that a frame that resumed would show up as a low line. It judges the result at the ports: the line is low at once, ready is 0, and no byte is taken. After break is released, the line stays high and busy stays low over several frame lengths. A normal frame sent next must then match the scoreboard.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } uftState_t;

  // framing fields of the line-control word (break kept separate)
  typedef struct packed {
    logic       forceP;
    logic       evenP;
    logic       parEn;
    logic       stopLong;
    logic [1:0] wordCode;
  } uftCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic dataBit;
    logic parityBit;
    logic stopBit;
    logic abort;
  } uftStrobe_t;

endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl
  import uft_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       brk,
  input  logic       txValid,
  input  logic [1:0] heldWordCode,
  input  logic       heldParEn,
  input  logic       heldStopLong,
  output logic       txReady,
  output logic       busy,
  output uftStrobe_t strb
);

  localparam int TCNT_W = $clog2(2 * OVS);
  localparam logic [TCNT_W-1:0] BIT_LAST   = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] STOP_ONE   = TCNT_W'(OVS - 1);
  localparam logic [TCNT_W-1:0] STOP_HALF  = TCNT_W'(OVS + OVS / 2 - 1);
  localparam logic [TCNT_W-1:0] STOP_TWO   = TCNT_W'(2 * OVS - 1);

  uftState_t         state, stateNext;
  logic [TCNT_W-1:0] tickCnt;
  logic [2:0]        bitIdx;
  logic [2:0]        wordLast;
  logic [TCNT_W-1:0] stopLast;
  logic              bitEnd, stopEnd;

  assign wordLast = 3'd4 + {1'b0, heldWordCode};
  assign stopLast = !heldStopLong          ? STOP_ONE  :
                    (heldWordCode == 2'd0) ? STOP_HALF : STOP_TWO;
  assign bitEnd   = baudTick && (tickCnt == BIT_LAST);
  assign stopEnd  = baudTick && (tickCnt == stopLast);

  assign txReady = (state == ST_IDLE) && !brk;
  assign busy    = (state != ST_IDLE) || brk;

  always_comb begin
    strb      = '0;
    stateNext = state;
    if (brk) begin
      if (state != ST_IDLE) begin
        strb.abort = 1'b1;
        stateNext  = ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_IDLE: if (txValid) begin
          strb.load = 1'b1;
          stateNext = ST_START;
        end
        ST_START: if (bitEnd) begin
          strb.dataBit = 1'b1;
          stateNext    = ST_DATA;
        end
        ST_DATA: if (bitEnd) begin
          if (bitIdx == wordLast) begin
            if (heldParEn) begin
              strb.parityBit = 1'b1;
              stateNext      = ST_PARITY;
            end else begin
              strb.stopBit = 1'b1;
              stateNext    = ST_STOP;
            end
          end else begin
            strb.dataBit = 1'b1;
          end
        end
        ST_PARITY: if (bitEnd) begin
          strb.stopBit = 1'b1;
          stateNext    = ST_STOP;
        end
        ST_STOP: if (stopEnd) stateNext = ST_IDLE;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state <= stateNext;
      if (stateNext == ST_IDLE || stateNext != state || strb.dataBit)
        tickCnt <= '0;
      else if (baudTick)
        tickCnt <= tickCnt + 1'b1;
      if (strb.load)
        bitIdx <= '0;
      else if (strb.dataBit && state == ST_DATA)
        bitIdx <= bitIdx + 1'b1;
    end
  end

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_STOP && !baudTick && !brk) |=> $stable(state)); // R2

  AST_BITIDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (bitIdx <= wordLast)); // R2

endmodule

// File: rtl/uft_datapath.sv
module uft_datapath
  import uft_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  uftStrobe_t        strb,
  input  uftCfg_t           cfgIn,
  input  logic              brk,
  input  logic [DATA_W-1:0] txData,
  output logic [1:0]        heldWordCode,
  output logic              heldParEn,
  output logic              heldStopLong,
  output logic              txOut
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataMask;
  logic              lineReg;
  logic              parReg;
  logic              onesOdd;
  logic              parNext;

  // bits below MIN_W always count; higher ones depend on the word code
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    if (g < MIN_W) begin : g_fixed
      assign dataMask[g] = 1'b1;
    end else begin : g_sel
      assign dataMask[g] = (int'(cfgIn.wordCode) >= (g - MIN_W + 1));
    end
  end

  assign onesOdd = ^(txData & dataMask);
  assign parNext = cfgIn.forceP ? !cfgIn.evenP :
                   cfgIn.evenP  ? onesOdd : !onesOdd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg     <= '0;
      lineReg      <= 1'b1;
      parReg       <= 1'b0;
      heldWordCode <= '0;
      heldParEn    <= 1'b0;
      heldStopLong <= 1'b0;
    end else begin
      if (strb.load) begin
        shiftReg     <= txData;
        parReg       <= parNext;
        lineReg      <= 1'b0;
        heldWordCode <= cfgIn.wordCode;
        heldParEn    <= cfgIn.parEn;
        heldStopLong <= cfgIn.stopLong;
      end else if (strb.dataBit) begin
        lineReg  <= shiftReg[0];
        shiftReg <= shiftReg >> 1;
      end else if (strb.parityBit) begin
        lineReg <= parReg;
      end else if (strb.stopBit || strb.abort) begin
        lineReg <= 1'b1;
      end
    end
  end

  assign txOut = brk ? 1'b0 : lineReg;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable({heldWordCode, heldParEn, heldStopLong})); // R10

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uft_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [6:0]        lineCtrl,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txOut,
  output logic              busy
);

  uftCfg_t    cfgIn;
  uftStrobe_t strb;
  logic       brk;
  logic [1:0] heldWordCode;
  logic       heldParEn;
  logic       heldStopLong;

  assign cfgIn = uftCfg_t'(lineCtrl[5:0]);
  assign brk   = lineCtrl[6];

  uft_ctrl #(.OVS(OVS)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .baudTick     (baudTick),
    .brk          (brk),
    .txValid      (txValid),
    .heldWordCode (heldWordCode),
    .heldParEn    (heldParEn),
    .heldStopLong (heldStopLong),
    .txReady      (txReady),
    .busy         (busy),
    .strb         (strb)
  );

  uft_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .cfgIn        (cfgIn),
    .brk          (brk),
    .txData       (txData),
    .heldWordCode (heldWordCode),
    .heldParEn    (heldParEn),
    .heldStopLong (heldStopLong),
    .txOut        (txOut)
  );

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txOut); // R2

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txOut); // R1

  AST_BREAK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(brk) |-> (txOut && !busy)); // R9

endmodule

// File: tb/test_uart_frame_tx.sv
`timescale 1ns/100ps
module test_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [6:0] lineCtrl = '0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady, txOut, busy;

  int checks = 0;
  int errors = 0;
  int framesDone = 0;
  bit monOn = 1'b1;
  int tickDiv = 0;

  typedef struct {
    logic [7:0] data;
    logic [6:0] ctrl;
  } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lineCtrl(lineCtrl),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txOut(txOut), .busy(busy)
  );

  // one tick every third clock
  always @(negedge clk) begin
    tickDiv  <= (tickDiv == 2) ? 0 : tickDiv + 1;
    baudTick <= (tickDiv == 2);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sendFrame(input logic [7:0] data, input logic [6:0] ctrl, input bit track);
    @(negedge clk);
    lineCtrl = ctrl;
    txData   = data;
    txValid  = 1'b1;
    #1;
    while (!txReady) begin
      @(negedge clk);
      #1;
    end
    if (track) sbq.push_back('{data, ctrl});
    @(posedge clk);
    #1;
    check(txReady == 1'b0 && busy == 1'b1, "R3 accept", {txReady, busy}, 2'b01);
    @(negedge clk);
    txValid  = 1'b0;
    lineCtrl = ctrl ^ 7'h3F; // R10: framing scrambled mid-frame
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    bit         inFrame = 0;
    int         ticks = 0;
    int         nBits = 0;
    int         stopT = 0;
    int         wl = 0;
    bit         parOn = 0;
    bit         forced = 0;
    logic       expBits [0:9];
    item_t      it;
    forever begin
      bit ticked;
      @(posedge clk);
      ticked = inFrame && baudTick;
      if (ticked) ticks++;
      #1;
      if (!monOn) begin
        inFrame = 0;
      end else if (!inFrame) begin
        if (rstN && txOut == 1'b0) begin
          if (sbq.size() == 0) begin
            check(1'b0, "R2 unexpected frame", 0, 1);
          end else begin
            logic [7:0] m;
            logic       ones;
            it     = sbq.pop_front();
            wl     = 5 + int'(it.ctrl[1:0]);
            parOn  = it.ctrl[3];
            forced = it.ctrl[5];
            m      = 8'hFF >> (8 - wl);
            ones   = ^(it.data & m);
            expBits[0] = 1'b0;
            for (int k = 0; k < 8; k++) if (k < wl) expBits[k+1] = it.data[k];
            if (parOn) expBits[wl+1] = forced ? !it.ctrl[4] : (it.ctrl[4] ? ones : !ones);
            nBits = 1 + wl + (parOn ? 1 : 0);
            stopT = !it.ctrl[2] ? 16 : (wl == 5 ? 24 : 32);
            inFrame = 1;
            ticks = 0;
          end
        end
      end else if (ticked) begin
        if (ticks % 16 == 8 && ticks / 16 < nBits) begin
          int k;
          k = ticks / 16;
          if (k == 0)
            check(txOut == 1'b0, "R2 start bit", txOut, 0);
          else if (k <= wl)
            check(txOut == expBits[k], "R2 data bit", txOut, expBits[k]);
          else if (forced)
            check(txOut == expBits[k], "R7 forced parity", txOut, expBits[k]);
          else
            check(txOut == expBits[k], "R6 parity", txOut, expBits[k]);
        end
        if (ticks == nBits * 16 + 8)
          check(txOut == 1'b1, parOn ? "R4 stop high" : "R5 no parity slot", txOut, 1);
        if (ticks == nBits * 16 + stopT - 1)
          check(busy == 1'b1, "R4 stop length", busy, 1);
        if (ticks == nBits * 16 + stopT) begin
          check(busy == 1'b0 && txOut == 1'b1, "R10 frame end by held framing", {busy, txOut}, 2'b01);
          inFrame = 0;
          framesDone++;
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check(txOut == 1'b1 && busy == 1'b0 && txReady == 1'b1, "R1 reset state",
          {txOut, busy, txReady}, 3'b101);

    // R2 word lengths
    sendFrame(8'hA5, 7'h03, 1); waitIdle();
    sendFrame(8'h16, 7'h00, 1); waitIdle();
    sendFrame(8'h2B, 7'h01, 1); waitIdle();
    sendFrame(8'h5A, 7'h02, 1); waitIdle();
    // R4 stop lengths
    sendFrame(8'h0D, 7'h04, 1); waitIdle();
    sendFrame(8'hC3, 7'h07, 1); waitIdle();
    sendFrame(8'h21, 7'h05, 1); waitIdle();
    // R6 odd / even, masked data
    sendFrame(8'h37, 7'h0B, 1); waitIdle();
    sendFrame(8'h37, 7'h1B, 1); waitIdle();
    sendFrame(8'h00, 7'h1B, 1); waitIdle();
    sendFrame(8'hE1, 7'h08, 1); waitIdle();
    // R7 forced parity
    sendFrame(8'h00, 7'h2B, 1); waitIdle();
    sendFrame(8'hFF, 7'h3B, 1); waitIdle();
    // R3 back-to-back
    sendFrame(8'h81, 7'h0F, 1);
    sendFrame(8'h7E, 7'h03, 1);
    waitIdle();
    check(framesDone == 15, "R3 frame count", framesDone, 15);

    // R8 break raised together with an offered byte
    monOn = 1'b0;
    @(negedge clk);
    lineCtrl = 7'h43;
    txData   = 8'h55;
    txValid  = 1'b1;
    @(posedge clk);
    #1;
    check(txOut == 1'b0 && busy == 1'b1 && txReady == 1'b0, "R8 break idle",
          {txOut, busy, txReady}, 3'b010);
    begin
      bit allLow = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (txOut !== 1'b0 || txReady !== 1'b0) allLow = 0;
      end
      check(allLow, "R8 break held", allLow, 1);
    end
    @(negedge clk);
    lineCtrl = 7'h03;
    txValid  = 1'b0;
    @(posedge clk);
    #1;
    check(txOut == 1'b1 && busy == 1'b0, "R9 release idle", {txOut, busy}, 2'b10);
    begin
      bit quiet = 1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (txOut !== 1'b1 || busy !== 1'b0) quiet = 0;
      end
      check(quiet, "R8 offered byte not taken", quiet, 1);
    end

    // R9 break in the middle of a zero frame
    sendFrame(8'h00, 7'h03, 0);
    repeat (100) @(negedge clk);
    lineCtrl = 7'h40;
    @(posedge clk);
    #1;
    check(txOut == 1'b0 && busy == 1'b1, "R8 break mid-frame", {txOut, busy}, 2'b01);
    repeat (30) @(negedge clk);
    lineCtrl = 7'h03;
    @(posedge clk);
    #1;
    check(txOut == 1'b1 && busy == 1'b0, "R9 release mid-frame", {txOut, busy}, 2'b10);
    begin
      bit quiet = 1;
      for (int i = 0; i < 700; i++) begin
        @(negedge clk);
        if (txOut !== 1'b1 || busy !== 1'b0) quiet = 0;
      end
      check(quiet, "R9 frame dropped", quiet, 1);
    end
    monOn = 1'b1;
    repeat (2) @(negedge clk);
    sendFrame(8'h96, 7'h1B, 1); waitIdle();
    check(framesDone == 16, "R9 resume normal", framesDone, 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule